// File: doc/BRIEF.md
# Address-Keyed Stall and Wakeup Buffer

This block sits in front of a first-level cache coherence controller and feeds it one message per cycle from three sources: coherence responses from the network, coherence requests arriving from other agents, and load, fetch, store or replacement requests from the processor. Responses always win, then coherence requests, then processor traffic. The controller sees the chosen message on a single combinational output.

A processor request whose cache line is in the middle of a coherence transaction cannot be served yet. Instead of pushing it back into its queue to retry blindly, the block parks it in a small wait store tagged with the line address. Some response kinds finish the transaction on their line. When one of them is taken, the block raises a wakeup for that address. Every parked request for that address is then marked released. Released requests are reissued oldest first, ahead of any new processor request but behind the two coherence channels. The coherence state of each line is supplied by the controller as a code alongside the processor request. The block keeps no line state of its own.

Top module: `stall_wake_buf`

## Requirements
- R1: In each cycle at most one message is emitted. The order of precedence is: response, then coherence request, then released parked request, then new processor request. `out_src` is 2 for a response, 1 for a coherence request, 3 for a replayed parked request and 0 for a direct processor request.
- R2: A processor request whose line-state code is 4, 5, 6, 7, 8 or 9 (the transient states) is accepted into the wait store while `cpu_ready` is high, and nothing is emitted for it.
- R3: A coherence request, invalidation included, is never parked. It is emitted whenever no response is present (`creq_ready` equals the inverse of `rsp_valid`), and it never raises a wakeup.
- R4: A wakeup (`wake_valid` high with `wake_addr` equal to the response address) is raised exactly when a response of kind 1 (data, transaction complete), 2 (store permission granted) or 3 (writeback acknowledged) is taken. Kinds 0 and 4 to 7 raise none.
- R5: A wakeup releases every parked entry with the matching address. Released entries are replayed one per free output cycle in arrival order, carrying their original operation code. Entries for other addresses stay parked.
- R6: While any released entry is waiting, a new processor request with a non-transient line is held, with `cpu_ready` low.
- R7: The wait store holds 8 entries. When it is full, `cpu_ready` is low, and no accepted request is ever lost.
- R8: A wakeup for an address with no parked entry changes nothing. On the next cycle no replay appears, and a new processor request is served directly.
- R9: If a wakeup and the parking of a new request for the same address fall in the same cycle, the wakeup is applied first. The new entry stays parked until a later wakeup.
- R10: After reset the wait store is empty, nothing is emitted, `wake_valid` is low and `cpu_ready` is high.
- R11: A processor request whose line-state code is 0 to 3 or 10 to 15 is emitted directly with `out_src` 0 when nothing ranks above it. It keeps its operation code: 0 load, 1 fetch, 2 store, 3 replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid | input | 1 | Response present; always taken |
| rsp_kind | input | 3 | Response kind code |
| rsp_addr | input | ADDR_W | Response line address |
| creq_valid | input | 1 | Coherence request present |
| creq_ready | output | 1 | Coherence request taken this cycle |
| creq_kind | input | 2 | Coherence request kind (0 = invalidation) |
| creq_addr | input | ADDR_W | Coherence request line address |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Processor request taken (emitted or parked) |
| cpu_op | input | 2 | Processor operation code |
| cpu_addr | input | ADDR_W | Processor request line address |
| cpu_line_st | input | 4 | Current coherence state code of the processor request's line |
| out_valid | output | 1 | Message emitted to the controller |
| out_src | output | 2 | Source of the emitted message |
| out_op | output | 3 | Kind or operation code of the emitted message |
| out_addr | output | ADDR_W | Line address of the emitted message |
| wake_valid | output | 1 | Wakeup raised this cycle |
| wake_addr | output | ADDR_W | Address being woken |

## Verification
Two events can meet in one cycle: a completing response that wakes an address, and a new processor request for that same address that is being parked. The bench sets up this collision with one request already parked. It then presents the waking response and a second transient request for the same line together. It expects exactly one replay on the next idle cycle and silence after that, until a second wakeup lets the later request out. A second overlap, a replay that is due while the wait store is full, is used to show that a held processor request is accepted once a slot frees and is not lost.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [1:0] {
        SRC_CPU    = 2'd0,
        SRC_CREQ   = 2'd1,
        SRC_RSP    = 2'd2,
        SRC_REPLAY = 2'd3
    } src_e;

    typedef enum logic [3:0] {
        LN_INV         = 4'd0,
        LN_SHR         = 4'd1,
        LN_EXC         = 4'd2,
        LN_MOD         = 4'd3,
        LN_RD_WAIT     = 4'd4,
        LN_WR_WAIT     = 4'd5,
        LN_UPG_WAIT    = 4'd6,
        LN_RD_WAIT_INV = 4'd7,
        LN_EVICT_WAIT  = 4'd8,
        LN_SINK_ACK    = 4'd9
    } line_st_e;

    localparam logic [2:0] RK_PART_ACK  = 3'd0;
    localparam logic [2:0] RK_DATA_DONE = 3'd1;
    localparam logic [2:0] RK_GRANT     = 3'd2;
    localparam logic [2:0] RK_WB_ACK    = 3'd3;
    localparam logic [2:0] RK_DATA_PEND = 3'd4;

    // Line is between stable states: a processor access must wait.
    function automatic logic is_transient(logic [3:0] st);
        return (st >= LN_RD_WAIT) && (st <= LN_SINK_ACK);
    endfunction

    // Response kinds that close the outstanding transaction on their line.
    function automatic logic rsp_completes(logic [2:0] k);
        return (k == RK_DATA_DONE) || (k == RK_GRANT) || (k == RK_WB_ACK);
    endfunction

endpackage

// File: rtl/sw_arbiter.sv
module sw_arbiter #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // Fixed priority: lowest index wins (isolate lowest set bit).
    assign gnt = req & (~req + N'(1));
endmodule

// File: rtl/sw_wait_store.sv
module sw_wait_store #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 8,
    parameter int OP_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wake_en,
    input  logic [ADDR_W-1:0] wake_addr,
    input  logic              park_en,
    input  logic [ADDR_W-1:0] park_addr,
    input  logic [OP_W-1:0]   park_op,
    input  logic              pop_en,
    output logic              full,
    output logic              rel_avail,
    output logic [ADDR_W-1:0] rel_addr,
    output logic [OP_W-1:0]   rel_op
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [OP_W-1:0]   op;
    } ent_t;

    // Entries are kept compacted in arrival order: slot 0 is the oldest.
    logic [DEPTH-1:0] vld_q, rel_q, vld_n, rel_n, rel_w, hit;
    ent_t             ent_q [DEPTH];
    ent_t             ent_n [DEPTH];
    logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_n;
    logic [IDX_W-1:0] head_idx;
    logic             head_found;

    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        assign hit[g] = vld_q[g] && (ent_q[g].addr == wake_addr);
    end

    // Oldest released entry.
    always_comb begin
        head_found = 1'b0;
        head_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld_q[i] && rel_q[i]) begin
                head_found = 1'b1;
                head_idx   = IDX_W'(i);
            end
        end
    end

    assign rel_avail = head_found;
    assign rel_addr  = ent_q[head_idx].addr;
    assign rel_op    = ent_q[head_idx].op;
    assign full      = (cnt_q == CNT_W'(DEPTH));

    // Next state: wakeup on existing entries first, then removal, then append.
    always_comb begin
        rel_w   = rel_q | (wake_en ? hit : '0);
        cnt_mid = cnt_q - (pop_en ? CNT_W'(1) : CNT_W'(0));
        for (int i = 0; i < DEPTH; i++) begin
            int src;
            src = (pop_en && (i >= int'(head_idx))) ? i + 1 : i;
            if (src < DEPTH) begin
                vld_n[i] = vld_q[src];
                rel_n[i] = rel_w[src];
                ent_n[i] = ent_q[src];
            end else begin
                vld_n[i] = 1'b0;
                rel_n[i] = 1'b0;
                ent_n[i] = '0;
            end
            if (park_en && (i == int'(cnt_mid))) begin
                vld_n[i] = 1'b1;
                rel_n[i] = 1'b0;
                ent_n[i] = '{addr: park_addr, op: park_op};
            end
        end
        cnt_n = cnt_mid + (park_en ? CNT_W'(1) : CNT_W'(0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            rel_q <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            vld_q <= vld_n;
            rel_q <= rel_n;
            cnt_q <= cnt_n;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_n[i];
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        park_en |-> !full);

    p_count_matches_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q == CNT_W'($countones(vld_q)));

    p_pop_has_entry_r5: assert property (@(posedge clk) disable iff (rst)
        pop_en |-> rel_avail);

    p_pop_shrinks_r5: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !park_en) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/stall_wake_buf.sv
module stall_wake_buf #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rsp_valid,
    input  logic [2:0]        rsp_kind,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic              creq_valid,
    output logic              creq_ready,
    input  logic [1:0]        creq_kind,
    input  logic [ADDR_W-1:0] creq_addr,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [3:0]        cpu_line_st,
    output logic              out_valid,
    output logic [1:0]        out_src,
    output logic [2:0]        out_op,
    output logic [ADDR_W-1:0] out_addr,
    output logic              wake_valid,
    output logic [ADDR_W-1:0] wake_addr
);
    import sw_pkg::*;

    localparam int NSRC = 4;
    localparam int OP_W = 2;

    logic              transient, full, rel_avail, park_en, cpu_go;
    logic [ADDR_W-1:0] rel_addr;
    logic [OP_W-1:0]   rel_op;
    logic [NSRC-1:0]   req, gnt;
    src_e              src;

    assign transient = is_transient(cpu_line_st);
    assign cpu_go    = cpu_valid && !transient && !full;
    assign park_en   = cpu_valid && transient && !full;

    // Priority index order: response, coherence request, replay, processor.
    assign req = {cpu_go, rel_avail, creq_valid, rsp_valid};

    sw_arbiter #(.N(NSRC)) arb_i (
        .req (req),
        .gnt (gnt)
    );

    assign wake_valid = rsp_valid && rsp_completes(rsp_kind);
    assign wake_addr  = rsp_addr;

    sw_wait_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .OP_W(OP_W)) store_i (
        .clk       (clk),
        .rst       (rst),
        .wake_en   (wake_valid),
        .wake_addr (rsp_addr),
        .park_en   (park_en),
        .park_addr (cpu_addr),
        .park_op   (cpu_op),
        .pop_en    (gnt[2]),
        .full      (full),
        .rel_avail (rel_avail),
        .rel_addr  (rel_addr),
        .rel_op    (rel_op)
    );

    assign creq_ready = !rsp_valid;
    assign cpu_ready  = !full && (transient || (!rsp_valid && !creq_valid && !rel_avail));

    always_comb begin
        src      = SRC_CPU;
        out_op   = {1'b0, cpu_op};
        out_addr = cpu_addr;
        if (gnt[0]) begin
            src      = SRC_RSP;
            out_op   = rsp_kind;
            out_addr = rsp_addr;
        end else if (gnt[1]) begin
            src      = SRC_CREQ;
            out_op   = {1'b0, creq_kind};
            out_addr = creq_addr;
        end else if (gnt[2]) begin
            src      = SRC_REPLAY;
            out_op   = {1'b0, rel_op};
            out_addr = rel_addr;
        end
    end

    assign out_valid = |gnt;
    assign out_src   = src;

    p_one_grant_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    p_rsp_first_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (out_valid && out_src == SRC_RSP));

    p_creq_no_wake_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_src == SRC_CREQ) |-> !wake_valid);

    p_wake_on_rsp_r4: assert property (@(posedge clk) disable iff (rst)
        wake_valid |-> (out_src == SRC_RSP && wake_addr == out_addr));

    p_replay_first_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_src == SRC_CPU) |-> !rel_avail);

    p_full_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        full |-> !cpu_ready);

endmodule

// File: tb/stall_wake_buf_tb_top.sv
module stall_wake_buf_tb_top;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rsp_valid = 0, creq_valid = 0, cpu_valid = 0;
    logic [2:0]    rsp_kind = 0;
    logic [1:0]    creq_kind = 0, cpu_op = 0;
    logic [AW-1:0] rsp_addr = 0, creq_addr = 0, cpu_addr = 0;
    logic [3:0]    cpu_line_st = 0;
    logic          creq_ready, cpu_ready, out_valid, wake_valid;
    logic [1:0]    out_src;
    logic [2:0]    out_op;
    logic [AW-1:0] out_addr, wake_addr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    stall_wake_buf #(.ADDR_W(AW), .DEPTH(8)) dut_i (
        .clk(clk), .rst(rst),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_addr(rsp_addr),
        .creq_valid(creq_valid), .creq_ready(creq_ready),
        .creq_kind(creq_kind), .creq_addr(creq_addr),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_op(cpu_op),
        .cpu_addr(cpu_addr), .cpu_line_st(cpu_line_st),
        .out_valid(out_valid), .out_src(out_src), .out_op(out_op),
        .out_addr(out_addr), .wake_valid(wake_valid), .wake_addr(wake_addr)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_out(string tag, logic v, logic [1:0] s, logic [AW-1:0] a, logic [2:0] op);
        chk({tag, " valid"}, 32'(out_valid), 32'(v));
        if (v) begin
            chk({tag, " src"}, 32'(out_src), 32'(s));
            chk({tag, " addr"}, 32'(out_addr), 32'(a));
            chk({tag, " op"}, 32'(out_op), 32'(op));
        end
    endtask

    // Advance to the next falling edge with all inputs idle.
    task automatic step();
        @(negedge clk);
        rsp_valid = 0; creq_valid = 0; cpu_valid = 0;
        rsp_kind = 0; creq_kind = 0; cpu_op = 0; cpu_line_st = 0;
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        step(); step();
        rst = 0;
    endtask

    task automatic park(logic [AW-1:0] a, logic [1:0] op, logic [3:0] st, string tag);
        step();
        cpu_valid = 1; cpu_addr = a; cpu_op = op; cpu_line_st = st;
        settle();
        chk({tag, " park ready"}, 32'(cpu_ready), 32'd1);
        chk({tag, " park silent"}, 32'(out_valid), 32'd0);
    endtask

    task automatic wake(logic [AW-1:0] a, logic [2:0] k);
        step();
        rsp_valid = 1; rsp_addr = a; rsp_kind = k;
        settle();
        chk("R4 wake raised", 32'(wake_valid), 32'd1);
        chk("R4 wake addr", 32'(wake_addr), 32'(a));
    endtask

    task automatic expect_replay(logic [AW-1:0] a, logic [1:0] op, string tag);
        step(); settle();
        chk_out(tag, 1'b1, 2'd3, a, {1'b0, op});
    endtask

    task automatic expect_idle(string tag);
        step(); settle();
        chk_out(tag, 1'b0, 2'd0, '0, 3'd0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        do_reset();
        settle();
        // R10: reset state
        chk("R10 out_valid", 32'(out_valid), 32'd0);
        chk("R10 wake_valid", 32'(wake_valid), 32'd0);
        chk("R10 cpu_ready", 32'(cpu_ready), 32'd1);

        // R1 / R3 / R11: priority sweep over all valid combinations
        for (int m = 0; m < 8; m++) begin
            logic r, c, p;
            logic [1:0] es;
            logic [AW-1:0] ea;
            logic [2:0] eo;
            step();
            r = m[2]; c = m[1]; p = m[0];
            rsp_valid = r; rsp_kind = 3'd0; rsp_addr = 8'hA1;
            creq_valid = c; creq_kind = 2'd1; creq_addr = 8'hB2;
            cpu_valid = p; cpu_op = 2'd2; cpu_addr = 8'hC3; cpu_line_st = 4'd3;
            settle();
            es = r ? 2'd2 : (c ? 2'd1 : 2'd0);
            ea = r ? 8'hA1 : (c ? 8'hB2 : 8'hC3);
            eo = r ? 3'd0 : (c ? 3'd1 : 3'd2);
            chk_out("R1 priority", r | c | p, es, ea, eo);
            chk("R3 creq_ready", 32'(creq_ready), 32'(!r));
            chk("R11 cpu_ready", 32'(cpu_ready), 32'(!r && !c));
            chk("R4 no wake kind0", 32'(wake_valid), 32'd0);
        end

        // R2 / R11: sweep all line-state codes, one distinct address each
        for (int s = 0; s < 16; s++) begin
            logic tr;
            step();
            tr = (s >= 4) && (s <= 9);
            cpu_valid = 1; cpu_addr = AW'(8'h80 + s); cpu_op = 2'(s); cpu_line_st = 4'(s);
            settle();
            chk("R2 ready", 32'(cpu_ready), 32'd1);
            chk_out(tr ? "R2 parked" : "R11 direct", !tr, 2'd0, AW'(8'h80 + s), 3'(s % 4));
        end

        // R4: response kind sweep on an unused address; R8: no effect
        for (int k = 0; k < 8; k++) begin
            step();
            rsp_valid = 1; rsp_kind = 3'(k); rsp_addr = 8'h11;
            settle();
            chk("R4 wake by kind", 32'(wake_valid), 32'((k >= 1) && (k <= 3)));
            chk_out("R4 rsp emitted", 1'b1, 2'd2, 8'h11, 3'(k));
        end
        expect_idle("R8 no replay after unmatched wakes");

        // R5: release by address in arrival order
        do_reset();
        park(8'h10, 2'd0, 4'd4, "R5");
        park(8'h20, 2'd2, 4'd5, "R5");
        park(8'h10, 2'd2, 4'd6, "R5");
        park(8'h10, 2'd1, 4'd8, "R5");
        park(8'h20, 2'd0, 4'd9, "R5");
        wake(8'h10, 3'd2);
        expect_replay(8'h10, 2'd0, "R5 first A");
        expect_replay(8'h10, 2'd2, "R5 second A");
        expect_replay(8'h10, 2'd1, "R5 third A");
        expect_idle("R5 B still parked");
        wake(8'h20, 3'd3);
        expect_replay(8'h20, 2'd2, "R5 first B");
        expect_replay(8'h20, 2'd0, "R5 second B");
        expect_idle("R5 drained");

        // R6: replay yields to coherence request, beats new processor request
        do_reset();
        park(8'h30, 2'd0, 4'd4, "R6");
        park(8'h30, 2'd3, 4'd4, "R6");
        wake(8'h30, 3'd1);
        step();
        creq_valid = 1; creq_addr = 8'h31; creq_kind = 2'd0;
        cpu_valid = 1; cpu_addr = 8'h32; cpu_op = 2'd1; cpu_line_st = 4'd1;
        settle();
        chk_out("R6 creq over replay", 1'b1, 2'd1, 8'h31, 3'd0);
        chk("R6 cpu held", 32'(cpu_ready), 32'd0);
        step();
        cpu_valid = 1; cpu_addr = 8'h32; cpu_op = 2'd1; cpu_line_st = 4'd1;
        settle();
        chk_out("R6 replay over cpu", 1'b1, 2'd3, 8'h30, 3'd0);
        chk("R6 cpu held on replay", 32'(cpu_ready), 32'd0);
        step();
        cpu_valid = 1; cpu_addr = 8'h32; cpu_op = 2'd1; cpu_line_st = 4'd1;
        settle();
        chk_out("R6 second replay", 1'b1, 2'd3, 8'h30, 3'd3);
        step();
        cpu_valid = 1; cpu_addr = 8'h32; cpu_op = 2'd1; cpu_line_st = 4'd1;
        settle();
        chk_out("R6 cpu after drain", 1'b1, 2'd0, 8'h32, 3'd1);

        // R7: full store blocks, nothing lost
        do_reset();
        for (int i = 0; i < 8; i++) park(AW'(8'h40 + i), 2'd2, 4'd5, "R7");
        step();
        cpu_valid = 1; cpu_addr = 8'h50; cpu_op = 2'd1; cpu_line_st = 4'd5;
        settle();
        chk("R7 full ready low", 32'(cpu_ready), 32'd0);
        chk("R7 full silent", 32'(out_valid), 32'd0);
        step();
        cpu_valid = 1; cpu_addr = 8'h50; cpu_op = 2'd1; cpu_line_st = 4'd5;
        rsp_valid = 1; rsp_addr = 8'h43; rsp_kind = 3'd3;
        settle();
        chk("R7 wake while full", 32'(wake_valid), 32'd1);
        chk("R7 still blocked", 32'(cpu_ready), 32'd0);
        step();
        cpu_valid = 1; cpu_addr = 8'h50; cpu_op = 2'd1; cpu_line_st = 4'd5;
        settle();
        chk_out("R7 replay from full", 1'b1, 2'd3, 8'h43, 3'd2);
        chk("R7 full during replay", 32'(cpu_ready), 32'd0);
        step();
        cpu_valid = 1; cpu_addr = 8'h50; cpu_op = 2'd1; cpu_line_st = 4'd5;
        settle();
        chk("R7 slot freed", 32'(cpu_ready), 32'd1);
        wake(8'h50, 3'd1);
        expect_replay(8'h50, 2'd1, "R7 held request kept");

        // R9: wakeup and park for the same address in one cycle
        do_reset();
        park(8'h60, 2'd0, 4'd4, "R9");
        step();
        rsp_valid = 1; rsp_addr = 8'h60; rsp_kind = 3'd1;
        cpu_valid = 1; cpu_addr = 8'h60; cpu_op = 2'd2; cpu_line_st = 4'd4;
        settle();
        chk("R9 wake", 32'(wake_valid), 32'd1);
        chk("R9 park accepted", 32'(cpu_ready), 32'd1);
        chk_out("R9 rsp out", 1'b1, 2'd2, 8'h60, 3'd1);
        expect_replay(8'h60, 2'd0, "R9 older released");
        expect_idle("R9 newer stays parked");
        wake(8'h60, 3'd2);
        expect_replay(8'h60, 2'd2, "R9 newer after second wake");

        // R3 / R4 / R8: invalidation and non-completing responses do not wake
        do_reset();
        park(8'h70, 2'd3, 4'd9, "R3");
        step();
        creq_valid = 1; creq_addr = 8'h70; creq_kind = 2'd0;
        settle();
        chk_out("R3 inv emitted", 1'b1, 2'd1, 8'h70, 3'd0);
        chk("R3 inv no wake", 32'(wake_valid), 32'd0);
        expect_idle("R3 nothing released");
        step();
        rsp_valid = 1; rsp_addr = 8'h70; rsp_kind = 3'd4;
        settle();
        chk("R4 pending data no wake", 32'(wake_valid), 32'd0);
        expect_idle("R4 nothing released");
        wake(8'h77, 3'd1);
        step();
        cpu_valid = 1; cpu_addr = 8'h71; cpu_op = 2'd1; cpu_line_st = 4'd2;
        settle();
        chk_out("R8 direct after stray wake", 1'b1, 2'd0, 8'h71, 3'd1);
        wake(8'h70, 3'd3);
        expect_replay(8'h70, 2'd3, "R8 parked entry intact");

        step();
        finish_run();
    end
endmodule